// File: doc/BRIEF.md
# Boundary-scan test access port

This block is a serial test access port for chip-level boundary scan. A four-wire test interface drives a 16-state controller: a test clock, a mode select, serial data in and an active-low asynchronous reset. A 4-bit instruction register picks one of three data paths between serial-in and serial-out. These paths are a fixed 32-bit identification word, a single bypass cell, and a chain of boundary cells with one cell per pin.

Toward the core, the block takes the sampled pin levels and the core's own output values and enables. It returns the values and enables that actually reach the pads. In normal operation the core's values pass straight through. Two instructions override the pads: one drives them from values preloaded through the chain, and the other releases every driver. While either override is active, only the bypass cell sits in the scan path.

Top module: `scan_tap`

## Requirements
- R1: After `trst_n` is asserted, the identification instruction (opcode 0x3) is active. A data scan then returns the 32-bit word {version[3:0], part[15:0], maker[10:0], 1'b1}, least significant bit first.
- R2: Holding `tms` high for five rising edges of `tck` from any state returns the controller to its reset state and reinstates the identification instruction.
- R3: Capture-IR loads 4'b0001 into the 4-bit instruction shift path. Shift-IR presents it on `tdo` least significant bit first, and new opcode bits enter at bit 3.
- R4: Opcode 0x2 (sample/preload) selects a chain of NUM_CELLS cells. Capture-DR loads `pin_in`, and cell 0 is the one nearest `tdo`.
- R5: Under every instruction except clamp and float, `pin_out` equals `core_out` and `pin_oe` equals `core_oe`. This holds even after sample/preload has updated its latches.
- R6: Opcode 0xF (bypass) selects a one-bit path that captures 0, so `tdi` reaches `tdo` one shift later.
- R7: Opcode 0x4 (clamp) drives `pin_out` from the update latches and, with CLAMP_OE_ALL=1, sets all of `pin_oe`. The bypass cell is the data path.
- R8: Opcode 0x5 (float) clears all of `pin_oe`. The bypass cell is the data path.
- R9: Any opcode outside {0x2, 0x3, 0x4, 0x5, 0xF} behaves as bypass.
- R10: `tdo_en` is high only while the controller is in Shift-DR or Shift-IR. Both `tdo` and `tdo_en` change on the falling edge of `tck`.
- R11: A newly shifted opcode takes effect only on the falling edge of `tck` in Update-IR. The previous instruction keeps control through Shift-IR and Exit1-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, valid while `tdo_en` is high |
| tdo_en | output | 1 | Output enable for the serial-out driver |
| pin_in | input | NUM_CELLS | Levels sampled at the pads |
| core_out | input | NUM_CELLS | Values the core wants to drive |
| core_oe | input | NUM_CELLS | Core output enables |
| pin_out | output | NUM_CELLS | Values sent to the pads |
| pin_oe | output | NUM_CELLS | Enables sent to the pads |

## Verification
The properties assume that `trst_n` is held low across at least two rising edges of `tck`. They also assume that `tms`, `tdi`, `pin_in`, `core_out` and `core_oe` never change at a rising edge. The stimulus meets both conditions. The serial inputs are driven just after each falling edge, and the pad-side inputs change only one nanosecond after a rising edge while the controller idles. Each reset pulse spans several clock periods, so the instruction and latch history seen by past-value checks always starts from the reset values.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/1ps
package scan_tap_pkg;

   localparam int IR_W = 4;

   localparam logic [IR_W-1:0] OPC_IDENT  = 4'h3;
   localparam logic [IR_W-1:0] OPC_SCAN   = 4'h2;
   localparam logic [IR_W-1:0] OPC_PASS   = 4'hF;
   localparam logic [IR_W-1:0] OPC_CLAMP  = 4'h4;
   localparam logic [IR_W-1:0] OPC_FLOAT  = 4'h5;
   localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

   typedef enum logic [3:0] {
      TS_RESET    = 4'd0,
      TS_IDLE     = 4'd1,
      TS_DR_SEL   = 4'd2,
      TS_DR_CAP   = 4'd3,
      TS_DR_SHIFT = 4'd4,
      TS_DR_EXIT1 = 4'd5,
      TS_DR_PAUSE = 4'd6,
      TS_DR_EXIT2 = 4'd7,
      TS_DR_UPD   = 4'd8,
      TS_IR_SEL   = 4'd9,
      TS_IR_CAP   = 4'd10,
      TS_IR_SHIFT = 4'd11,
      TS_IR_EXIT1 = 4'd12,
      TS_IR_PAUSE = 4'd13,
      TS_IR_EXIT2 = 4'd14,
      TS_IR_UPD   = 4'd15
   } tap_st_e;

   typedef enum logic [2:0] {
      MODE_IDENT = 3'd0,
      MODE_SCAN  = 3'd1,
      MODE_PASS  = 3'd2,
      MODE_CLAMP = 3'd3,
      MODE_FLOAT = 3'd4
   } ins_e;

   function automatic ins_e decode_op(input logic [IR_W-1:0] op);
      ins_e r;
      case (op)
         OPC_IDENT: r = MODE_IDENT;
         OPC_SCAN:  r = MODE_SCAN;
         OPC_CLAMP: r = MODE_CLAMP;
         OPC_FLOAT: r = MODE_FLOAT;
         default:   r = MODE_PASS;
      endcase
      return r;
   endfunction

   function automatic tap_st_e tap_next(input tap_st_e s, input logic m);
      tap_st_e n;
      case (s)
         TS_RESET:    n = m ? TS_RESET    : TS_IDLE;
         TS_IDLE:     n = m ? TS_DR_SEL   : TS_IDLE;
         TS_DR_SEL:   n = m ? TS_IR_SEL   : TS_DR_CAP;
         TS_DR_CAP:   n = m ? TS_DR_EXIT1 : TS_DR_SHIFT;
         TS_DR_SHIFT: n = m ? TS_DR_EXIT1 : TS_DR_SHIFT;
         TS_DR_EXIT1: n = m ? TS_DR_UPD   : TS_DR_PAUSE;
         TS_DR_PAUSE: n = m ? TS_DR_EXIT2 : TS_DR_PAUSE;
         TS_DR_EXIT2: n = m ? TS_DR_UPD   : TS_DR_SHIFT;
         TS_DR_UPD:   n = m ? TS_DR_SEL   : TS_IDLE;
         TS_IR_SEL:   n = m ? TS_RESET    : TS_IR_CAP;
         TS_IR_CAP:   n = m ? TS_IR_EXIT1 : TS_IR_SHIFT;
         TS_IR_SHIFT: n = m ? TS_IR_EXIT1 : TS_IR_SHIFT;
         TS_IR_EXIT1: n = m ? TS_IR_UPD   : TS_IR_PAUSE;
         TS_IR_PAUSE: n = m ? TS_IR_EXIT2 : TS_IR_PAUSE;
         TS_IR_EXIT2: n = m ? TS_IR_UPD   : TS_IR_SHIFT;
         default:     n = m ? TS_DR_SEL   : TS_IDLE;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
`timescale 1ns/1ps
module scan_tap_fsm
   import scan_tap_pkg::*;
(
   input  logic    tck,
   input  logic    trst_n,
   input  logic    tms,
   output tap_st_e st
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) st <= TS_RESET;
      else         st <= tap_next(st, tms);
   end

endmodule

// File: rtl/scan_tap_ir.sv
`timescale 1ns/1ps
module scan_tap_ir
   import scan_tap_pkg::*;
(
   input  logic    tck,
   input  logic    trst_n,
   input  tap_st_e st,
   input  logic    tdi,
   output logic    ir_so,
   output ins_e    ins
);

   logic [IR_W-1:0] sh_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sh_q <= IR_CAPTURE;
      end else begin
         case (st)
            TS_IR_CAP:   sh_q <= IR_CAPTURE;
            TS_IR_SHIFT: sh_q <= {tdi, sh_q[IR_W-1:1]};
            default: ;
         endcase
      end
   end

   // the active instruction moves on the falling edge only
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)               ins <= MODE_IDENT;
      else if (st == TS_RESET)   ins <= MODE_IDENT;
      else if (st == TS_IR_UPD)  ins <= decode_op(sh_q);
   end

   assign ir_so = sh_q[0];

endmodule

// File: rtl/scan_tap_bsr.sv
`timescale 1ns/1ps
module scan_tap_bsr
   import scan_tap_pkg::*;
#(
   parameter int NUM_CELLS = 8
) (
   input  logic                 tck,
   input  logic                 trst_n,
   input  tap_st_e              st,
   input  logic                 tdi,
   input  logic                 sel,
   input  logic [NUM_CELLS-1:0] pin_in,
   output logic                 so,
   output logic [NUM_CELLS-1:0] latch
);

   logic [NUM_CELLS:0] link;

   assign link[NUM_CELLS] = tdi;

   for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
      logic cap_q;
      logic upd_q;

      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n) begin
            cap_q <= 1'b0;
         end else if (sel) begin
            case (st)
               TS_DR_CAP:   cap_q <= pin_in[i];
               TS_DR_SHIFT: cap_q <= link[i+1];
               default: ;
            endcase
         end
      end

      always_ff @(negedge tck or negedge trst_n) begin
         if (!trst_n)                       upd_q <= 1'b0;
         else if (sel && st == TS_DR_UPD)   upd_q <= cap_q;
      end

      assign link[i]  = cap_q;
      assign latch[i] = upd_q;
   end

   assign so = link[0];

endmodule

// File: rtl/scan_tap.sv
`timescale 1ns/1ps
module scan_tap
   import scan_tap_pkg::*;
#(
   parameter int          NUM_CELLS    = 8,
   parameter logic [3:0]  ID_VERSION   = 4'h1,
   parameter logic [15:0] ID_PART      = 16'hA5C3,
   parameter logic [10:0] ID_MAKER     = 11'h0B5,
   parameter bit          CLAMP_OE_ALL = 1'b1
) (
   input  logic                 tck,
   input  logic                 trst_n,
   input  logic                 tms,
   input  logic                 tdi,
   output logic                 tdo,
   output logic                 tdo_en,
   input  logic [NUM_CELLS-1:0] pin_in,
   input  logic [NUM_CELLS-1:0] core_out,
   input  logic [NUM_CELLS-1:0] core_oe,
   output logic [NUM_CELLS-1:0] pin_out,
   output logic [NUM_CELLS-1:0] pin_oe
);

   localparam int          ID_W    = 32;
   localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

   if (NUM_CELLS < 1 || NUM_CELLS > 4096) begin : g_bad_cells
      $error("scan_tap: NUM_CELLS out of range");
   end

   tap_st_e              tap_st;
   ins_e                 cur_ins;
   logic                 ir_so;
   logic                 bsr_so;
   logic [NUM_CELLS-1:0] upd_q;
   logic [ID_W-1:0]      id_sh;
   logic                 byp_q;
   logic                 byp_sel;
   logic                 dr_so;
   logic [NUM_CELLS-1:0] clamp_oe;

   scan_tap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .st     (tap_st)
   );

   scan_tap_ir u_ir (
      .tck    (tck),
      .trst_n (trst_n),
      .st     (tap_st),
      .tdi    (tdi),
      .ir_so  (ir_so),
      .ins    (cur_ins)
   );

   scan_tap_bsr #(.NUM_CELLS(NUM_CELLS)) u_bsr (
      .tck    (tck),
      .trst_n (trst_n),
      .st     (tap_st),
      .tdi    (tdi),
      .sel    (cur_ins == MODE_SCAN),
      .pin_in (pin_in),
      .so     (bsr_so),
      .latch  (upd_q)
   );

   // identification word
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         id_sh <= ID_WORD;
      end else if (cur_ins == MODE_IDENT) begin
         case (tap_st)
            TS_DR_CAP:   id_sh <= ID_WORD;
            TS_DR_SHIFT: id_sh <= {tdi, id_sh[ID_W-1:1]};
            default: ;
         endcase
      end
   end

   // single bypass cell
   assign byp_sel = (cur_ins == MODE_PASS) || (cur_ins == MODE_CLAMP) ||
                    (cur_ins == MODE_FLOAT);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         byp_q <= 1'b0;
      end else if (byp_sel) begin
         case (tap_st)
            TS_DR_CAP:   byp_q <= 1'b0;
            TS_DR_SHIFT: byp_q <= tdi;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (cur_ins)
         MODE_IDENT: dr_so = id_sh[0];
         MODE_SCAN:  dr_so = bsr_so;
         default:    dr_so = byp_q;
      endcase
   end

   // serial output, launched on the falling edge
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo_en <= (tap_st == TS_DR_SHIFT) || (tap_st == TS_IR_SHIFT);
         tdo    <= (tap_st == TS_IR_SHIFT) ? ir_so : dr_so;
      end
   end

   if (CLAMP_OE_ALL) begin : g_clamp_drive
      assign clamp_oe = '1;
   end else begin : g_clamp_keep
      assign clamp_oe = core_oe;
   end

   always_comb begin
      pin_out = core_out;
      pin_oe  = core_oe;
      case (cur_ins)
         MODE_CLAMP: begin
            pin_out = upd_q;
            pin_oe  = clamp_oe;
         end
         MODE_FLOAT: pin_oe = '0;
         default: ;
      endcase
   end

endmodule

// File: rtl/scan_tap_chk.sv
`timescale 1ns/1ps
module scan_tap_chk
   import scan_tap_pkg::*;
#(
   parameter int N = 8
) (
   input logic         tck,
   input logic         trst_n,
   input logic         tdo_en,
   input tap_st_e      st,
   input ins_e         ins,
   input logic [N-1:0] core_out,
   input logic [N-1:0] core_oe,
   input logic [N-1:0] pin_out,
   input logic [N-1:0] pin_oe,
   input logic [N-1:0] latch
);

   // R10
   tdo_en_chk: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en == ((st == TS_DR_SHIFT) || (st == TS_IR_SHIFT)));

   // R1
   reset_ident_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st == TS_RESET && $past(st) == TS_RESET) |-> ins == MODE_IDENT);

   // R11
   ins_change_chk: assert property (@(posedge tck) disable iff (!trst_n)
      !$stable(ins) |-> (st == TS_IR_UPD || st == TS_RESET));

   // R5
   scan_pins_chk: assert property (@(posedge tck) disable iff (!trst_n)
      ins == MODE_SCAN |-> (pin_out == core_out && pin_oe == core_oe));

   // R7
   clamp_pins_chk: assert property (@(posedge tck) disable iff (!trst_n)
      ins == MODE_CLAMP |-> pin_out == latch);

   // R8
   float_pins_chk: assert property (@(posedge tck) disable iff (!trst_n)
      ins == MODE_FLOAT |-> pin_oe == '0);

endmodule

bind scan_tap scan_tap_chk #(.N(NUM_CELLS)) u_chk (
   .tck      (tck),
   .trst_n   (trst_n),
   .tdo_en   (tdo_en),
   .st       (tap_st),
   .ins      (cur_ins),
   .core_out (core_out),
   .core_oe  (core_oe),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .latch    (upd_q)
);

// File: tb/test_scan_tap.sv
`timescale 1ns/1ps
module test_scan_tap;

   localparam int NC = 8;
   localparam logic [31:0] IDW = {4'h1, 16'hA5C3, 11'h0B5, 1'b1};

   logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
   logic tdo, tdo_en;
   logic [NC-1:0] pin_in = '0, core_out = '0, core_oe = '0;
   logic [NC-1:0] pin_out, pin_oe;

   int checks = 0, errors = 0;

   scan_tap #(.NUM_CELLS(NC)) i_scan_tap (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
      .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
      .pin_out(pin_out), .pin_oe(pin_oe));

   always #2.5 tck = ~tck;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int ms = 0;
   logic [3:0] mop = 4'h3;
   logic [NC-1:0] mlat = '0;
   logic dq[$];
   logic iq[$];

   function automatic int nxt(input int s, input logic m);
      case (s)
         0: return m ? 0 : 1;    1: return m ? 2 : 1;
         2: return m ? 9 : 3;    3: return m ? 5 : 4;
         4: return m ? 5 : 4;    5: return m ? 8 : 6;
         6: return m ? 7 : 6;    7: return m ? 8 : 4;
         8: return m ? 2 : 1;    9: return m ? 0 : 10;
         10: return m ? 12 : 11; 11: return m ? 12 : 11;
         12: return m ? 15 : 13; 13: return m ? 14 : 13;
         14: return m ? 15 : 11; default: return m ? 2 : 1;
      endcase
   endfunction

   // 0 ident, 1 scan, 2 pass, 3 clamp, 4 float
   function automatic int pick(input logic [3:0] op);
      case (op)
         4'h3: return 0;
         4'h2: return 1;
         4'h4: return 3;
         4'h5: return 4;
         default: return 2;
      endcase
   endfunction

   always @(posedge tck) begin
      if (!trst_n) begin
         ms = 0;
      end else begin
         case (ms)
            3: begin
               dq.delete();
               case (pick(mop))
                  0: for (int k = 0; k < 32; k++) dq.push_back(IDW[k]);
                  1: for (int k = 0; k < NC; k++) dq.push_back(pin_in[k]);
                  default: dq.push_back(1'b0);
               endcase
            end
            4: begin void'(dq.pop_front()); dq.push_back(tdi); end
            10: begin
               iq.delete();
               iq.push_back(1'b1); iq.push_back(1'b0);
               iq.push_back(1'b0); iq.push_back(1'b0);
            end
            11: begin void'(iq.pop_front()); iq.push_back(tdi); end
            default: ;
         endcase
         ms = nxt(ms, tms);
      end
   end

   always @(negedge tck) begin
      logic          exp_en, exp_tdo;
      logic [NC-1:0] eo, ee;
      string         tg;
      int            p;
      if (!trst_n) begin
         mop = 4'h3; mlat = '0; ms = 0;
      end else begin
         if (ms == 15) mop = {iq[3], iq[2], iq[1], iq[0]};
         if (ms == 0) mop = 4'h3;
         if (ms == 8 && pick(mop) == 1)
            for (int k = 0; k < NC; k++) mlat[k] = dq[k];
      end
      #1;
      if (trst_n) begin
         exp_en = (ms == 4) || (ms == 11);
         check("R10 tdo_en", 64'(tdo_en), 64'(exp_en));
         p = pick(mop);
         if (exp_en) begin
            exp_tdo = (ms == 11) ? iq[0] : dq[0];
            tg = (ms == 11) ? "R3 tdo" : (p == 0) ? "R1 tdo" : (p == 1) ? "R4 tdo" : "R6 tdo";
            check(tg, 64'(tdo), 64'(exp_tdo));
         end
         eo = (p == 3) ? mlat : core_out;
         ee = (p == 3) ? '1 : (p == 4) ? '0 : core_oe;
         tg = (p == 3) ? "R7 pins" : (p == 4) ? "R8 pins" : "R5 pins";
         check(tg, {pin_out, pin_oe}, {eo, ee});
      end
   end

   // ---------------- stimulus ----------------
   task automatic tick(input logic m, input logic d, output logic so);
      @(negedge tck); #1;
      so = tdo; tms = m; tdi = d;
   endtask

   task automatic set_io(input logic [NC-1:0] pi, input logic [NC-1:0] co, input logic [NC-1:0] ce);
      @(posedge tck); #1;
      pin_in = pi; core_out = co; core_oe = ce;
   endtask

   task automatic ir_shift(input logic [3:0] op, output logic [63:0] r);
      logic b;
      r = '0;
      tick(1, 0, b); tick(1, 0, b); tick(0, 0, b); tick(0, 0, b);
      for (int i = 0; i < 4; i++) tick(i == 3, op[i], r[i]);
   endtask

   task automatic ir_scan(input logic [3:0] op, output logic [63:0] r);
      logic b;
      ir_shift(op, r);
      tick(1, 0, b); tick(0, 0, b);
   endtask

   task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] r);
      logic b;
      r = '0;
      tick(1, 0, b); tick(0, 0, b); tick(0, 0, b);
      for (int i = 0; i < n; i++) tick(i == n - 1, din[i], r[i]);
      tick(1, 0, b); tick(0, 0, b);
   endtask

   initial begin
      repeat (100000) @(posedge tck);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] res;
      logic b;
      repeat (3) @(negedge tck);
      #1 trst_n = 1'b1;
      tick(0, 0, b);
      // R10: idle keeps the serial driver off
      tick(0, 0, b);
      check("R10 idle", 64'(tdo_en), 64'd0);
      // R1: identification word after reset
      dr_scan(32, 64'd0, res);
      check("R1 id", res[31:0], IDW);
      // R3: capture pattern seen during IR shift
      ir_scan(4'h2, res);
      check("R3 capture", res[3:0], 4'b0001);
      // R4 / R5: sample pins, preload a pattern
      set_io(8'h5A, 8'hC3, 8'h0F);
      dr_scan(NC, 64'h96, res);
      check("R4 sample", res[NC-1:0], 8'h5A);
      check("R5 out", pin_out, 8'hC3);
      check("R5 oe", pin_oe, 8'h0F);
      // R7: clamp drives preloaded values, bypass path
      ir_scan(4'h4, res);
      check("R7 out", pin_out, 8'h96);
      check("R7 oe", pin_oe, 8'hFF);
      dr_scan(2, 64'b11, res);
      check("R7 bypass", res[1:0], 2'b10);
      set_io(8'h00, 8'h3C, 8'h00);
      check("R7 hold", pin_out, 8'h96);
      // R11: old instruction holds until Update-IR
      ir_shift(4'h5, res);
      tick(1, 0, b);
      check("R11 exit1 out", pin_out, 8'h96);
      check("R11 exit1 oe", pin_oe, 8'hFF);
      tick(0, 0, b);
      // R8: float releases all drivers
      check("R8 oe", pin_oe, 8'h00);
      check("R8 out", pin_out, 8'h3C);
      // R9: unassigned opcode acts as bypass
      ir_scan(4'hA, res);
      check("R9 pins", {pin_out, pin_oe}, {8'h3C, 8'h00});
      dr_scan(3, 64'b011, res);
      check("R9 path", res[2:0], 3'b110);
      // R6: explicit bypass
      ir_scan(4'hF, res);
      dr_scan(3, 64'b101, res);
      check("R6 path", res[2:0], 3'b010);
      // R2: five TMS-high cycles restore the ident instruction
      repeat (5) tick(1, 0, b);
      tick(0, 0, b);
      dr_scan(32, 64'd0, res);
      check("R2 id", res[31:0], IDW);
      // R1: asynchronous reset out of clamp
      ir_scan(4'h4, res);
      @(negedge tck); #1 trst_n = 1'b0; tms = 1'b1;
      repeat (3) @(negedge tck);
      #1 trst_n = 1'b1;
      tick(0, 0, b);
      check("R1 pins", {pin_out, pin_oe}, {8'h3C, 8'h00});
      dr_scan(32, 64'd0, res);
      check("R1 id after trst", res[31:0], IDW);
      repeat (2) tick(0, 0, b);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule